// File: doc/BRIEF.md
# 64-bit Integer Execute Stage

This block performs the arithmetic, logic, compare and shift work of a 64-bit RISC-V base integer pipeline. Each cycle it accepts a 32-bit instruction word, the two 64-bit source operand values already read from the register file, and the program counter of that instruction. One clock later it presents the 64-bit result, the destination register number, a write-enable for the register file, and a flag that marks an encoding it does not accept.

It handles the full-width register-register and register-immediate forms, the 32-bit "word" forms, and the two upper-immediate forms (load-upper and PC-relative upper). A word form truncates its result to 32 bits and then sign-extends it to 64 bits. Control transfer, memory access, register storage and system registers belong to other stages. An instruction this stage does not accept produces a zero result and no register write, so the pipeline only has to route the flag to its trap logic.

Top module: `rv64_exec_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, every output reads zero.
- R2: For major opcode 0110011, funct3 (bits 14:12) picks the operation: 000 add, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical shift right, 110 or, 111 and. When funct7 (bits 31:25) is 0100000, add becomes subtract and the logical right shift becomes arithmetic. Overflow wraps modulo 2^64. All outputs appear on the clock edge after the inputs.
- R3: Opcode 0010011 performs the same operations with a second operand equal to instruction bits 31:20, sign-extended from bit 31. No subtract form exists here.
- R4: A full-width shift uses only the low 6 bits of the shift amount. For an immediate shift, bits 31:26 must be 000000 (left or logical right) or 010000 (arithmetic right).
- R5: Opcodes 0111011 (register) and 0011011 (immediate) are the word forms. They support add, with subtract for the register form, plus shift left and shift right. Their result is the low 32 bits, with bit 31 copied into bits 63:32.
- R6: A word shift uses the low 5 bits of the shift amount, from either rs2 or the immediate. A word arithmetic right shift fills from bit 31 of rs1.
- R7: A word immediate shift that has instruction bit 25 set is flagged illegal.
- R8: A less-than result is exactly 0 or 1. The unsigned immediate compare treats both rs1 and the sign-extended immediate as unsigned.
- R9: Opcode 0110111 returns instruction bits 31:12 placed at bits 31:12, with zero low bits, sign-extended from bit 31. Opcode 0010111 returns the PC plus that same value.
- R10: The register number output equals instruction bits 11:7. The write-enable is low when that number is 0.
- R11: Any other opcode, or any funct7 value not listed above, raises the illegal flag, clears the write-enable and makes the result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| src1_i | input | 64 | Value of the first source register |
| src2_i | input | 64 | Value of the second source register |
| pc_i | input | 64 | PC of the instruction |
| result_o | output | 64 | Registered result |
| rd_o | output | 5 | Registered destination register number |
| wen_o | output | 1 | Registered register-file write-enable |
| illegal_o | output | 1 | Registered illegal-encoding flag |

## Verification
The assertions check the following on every cycle:
- the write-enable and the illegal flag are never high together;
- a write never targets register 0;
- an illegal instruction yields a zero result;
- the register number tracks the previous instruction word;
- a legal word form always produces a sign-extended result;
- a compare always returns 0 or 1;
- a load-upper result always has zero low bits.

The exact arithmetic values can only be shown by the bench's scenarios. These are the shift-amount masking, the sign fill of the word arithmetic shift, the unsigned immediate compare against a negative immediate, and the PC-relative sum. The bench compares them with its own model over random and directed instruction words.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int XLEN  = 64;
    localparam int ILEN  = 32;
    localparam int HALF  = XLEN / 2;
    localparam int SHW   = $clog2(XLEN);
    localparam int SHW_W = $clog2(HALF);
    localparam int REGW  = 5;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_REG_W  = 7'b0111011;
    localparam logic [6:0] OPC_IMM_W  = 7'b0011011;
    localparam logic [6:0] OPC_UPPER  = 7'b0110111;
    localparam logic [6:0] OPC_PCUP   = 7'b0010111;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR,
        OP_SRL, OP_SRA, OP_OR, OP_AND, OP_UPPER, OP_PCUP
    } alu_op_e;

    typedef struct packed {
        alu_op_e          op;
        logic             use_imm;
        logic             word;
        logic             illegal;
        logic [XLEN-1:0]  imm;
    } exu_ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic [REGW-1:0] rd;
        logic            wen;
        logic            illegal;
    } exu_out_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output exu_ctrl_t       ctrl_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [5:0] top6;

    assign opc  = instr_i[6:0];
    assign f3   = instr_i[14:12];
    assign f7   = instr_i[31:25];
    assign top6 = instr_i[31:26];

    always_comb begin
        ctrl_o         = '0;
        ctrl_o.op      = OP_ADD;
        ctrl_o.imm     = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};
        unique case (opc)
            OPC_REG, OPC_REG_W: begin
                ctrl_o.word = (opc == OPC_REG_W);
                unique case (f3)
                    3'b000: ctrl_o.op = (f7 == 7'b0100000) ? OP_SUB : OP_ADD;
                    3'b001: ctrl_o.op = OP_SLL;
                    3'b010: ctrl_o.op = OP_SLT;
                    3'b011: ctrl_o.op = OP_SLTU;
                    3'b100: ctrl_o.op = OP_XOR;
                    3'b101: ctrl_o.op = (f7 == 7'b0100000) ? OP_SRA : OP_SRL;
                    3'b110: ctrl_o.op = OP_OR;
                    default: ctrl_o.op = OP_AND;
                endcase
                if (f7 == 7'b0100000)
                    ctrl_o.illegal = !(f3 == 3'b000 || f3 == 3'b101);
                else
                    ctrl_o.illegal = (f7 != 7'b0000000);
                if (ctrl_o.word && !(f3 == 3'b000 || f3 == 3'b001 || f3 == 3'b101))
                    ctrl_o.illegal = 1'b1;
            end
            OPC_IMM, OPC_IMM_W: begin
                ctrl_o.word    = (opc == OPC_IMM_W);
                ctrl_o.use_imm = 1'b1;
                unique case (f3)
                    3'b000: ctrl_o.op = OP_ADD;
                    3'b001: ctrl_o.op = OP_SLL;
                    3'b010: ctrl_o.op = OP_SLT;
                    3'b011: ctrl_o.op = OP_SLTU;
                    3'b100: ctrl_o.op = OP_XOR;
                    3'b101: ctrl_o.op = (top6 == 6'b010000) ? OP_SRA : OP_SRL;
                    3'b110: ctrl_o.op = OP_OR;
                    default: ctrl_o.op = OP_AND;
                endcase
                if (f3 == 3'b001)
                    ctrl_o.illegal = (top6 != 6'b000000);
                else if (f3 == 3'b101)
                    ctrl_o.illegal = !(top6 == 6'b000000 || top6 == 6'b010000);
                if (ctrl_o.word) begin
                    if (f3 == 3'b001 || f3 == 3'b101) begin
                        if (instr_i[25]) ctrl_o.illegal = 1'b1;
                    end else if (f3 != 3'b000) begin
                        ctrl_o.illegal = 1'b1;
                    end
                end
            end
            OPC_UPPER, OPC_PCUP: begin
                ctrl_o.op  = (opc == OPC_UPPER) ? OP_UPPER : OP_PCUP;
                ctrl_o.imm = {{(XLEN-32){instr_i[31]}}, instr_i[31:12], 12'h000};
            end
            default: ctrl_o.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
(
    input  exu_ctrl_t       ctrl_i,
    input  logic [XLEN-1:0] src1_i,
    input  logic [XLEN-1:0] src2_i,
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] result_o
);
    logic [XLEN-1:0]        opb;
    logic [SHW-1:0]         shamt;
    logic [HALF-1:0]        lo;
    logic signed [HALF-1:0] lo_s;
    logic signed [XLEN-1:0] a_s;
    logic [XLEN-1:0]        raw;

    always_comb begin
        opb   = ctrl_i.use_imm ? ctrl_i.imm : src2_i;
        shamt = ctrl_i.word ? {{(SHW-SHW_W){1'b0}}, opb[SHW_W-1:0]} : opb[SHW-1:0];
        lo    = src1_i[HALF-1:0];
        lo_s  = $signed(lo) >>> shamt[SHW_W-1:0];
        a_s   = $signed(src1_i) >>> shamt;
        unique case (ctrl_i.op)
            OP_ADD:   raw = src1_i + opb;
            OP_SUB:   raw = src1_i - opb;
            OP_SLL:   raw = src1_i << shamt;
            OP_SLT:   raw = {{(XLEN-1){1'b0}}, $signed(src1_i) < $signed(opb)};
            OP_SLTU:  raw = {{(XLEN-1){1'b0}}, src1_i < opb};
            OP_XOR:   raw = src1_i ^ opb;
            OP_SRL:   raw = ctrl_i.word ? {{HALF{1'b0}}, lo >> shamt[SHW_W-1:0]}
                                        : src1_i >> shamt;
            OP_SRA:   raw = ctrl_i.word ? {{HALF{1'b0}}, lo_s} : a_s;
            OP_OR:    raw = src1_i | opb;
            OP_AND:   raw = src1_i & opb;
            OP_UPPER: raw = ctrl_i.imm;
            default:  raw = pc_i + ctrl_i.imm;
        endcase
        if (ctrl_i.word)
            result_o = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
        else
            result_o = raw;
    end
endmodule

// File: rtl/rv64_exec_unit.sv
module rv64_exec_unit
    import exu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr_i,
    input  logic [63:0]     src1_i,
    input  logic [63:0]     src2_i,
    input  logic [63:0]     pc_i,
    output logic [63:0]     result_o,
    output logic [4:0]      rd_o,
    output logic            wen_o,
    output logic            illegal_o
);
    exu_ctrl_t       ctrl;
    logic [XLEN-1:0] alu_res;
    exu_out_t        st_d, st_q;

    exu_decode u_dec (
        .instr_i (instr_i),
        .ctrl_o  (ctrl)
    );

    exu_alu u_alu (
        .ctrl_i   (ctrl),
        .src1_i   (src1_i),
        .src2_i   (src2_i),
        .pc_i     (pc_i),
        .result_o (alu_res)
    );

    always_comb begin
        st_d         = '0;
        st_d.rd      = instr_i[11:7];
        st_d.illegal = ctrl.illegal;
        st_d.wen     = !ctrl.illegal && (instr_i[11:7] != '0);
        st_d.result  = ctrl.illegal ? '0 : alu_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o  = st_q.result;
    assign rd_o      = st_q.rd;
    assign wen_o     = st_q.wen;
    assign illegal_o = st_q.illegal;
endmodule

// File: rtl/exu_chk.sv
module exu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic [63:0] result_o,
    input logic [4:0]  rd_o,
    input logic        wen_o,
    input logic        illegal_o
);
    logic is_word_op;
    logic is_cmp;
    assign is_word_op = (instr_i[6:0] == 7'b0111011) || (instr_i[6:0] == 7'b0011011);
    assign is_cmp     = ((instr_i[6:0] == 7'b0110011) || (instr_i[6:0] == 7'b0010011))
                        && (instr_i[14:13] == 2'b01);

    // R11
    wen_vs_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen_o && illegal_o));
    // R10
    no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen_o |-> rd_o != 5'd0);
    // R11
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> result_o == 64'd0);
    // R10
    rd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rd_o == $past(instr_i[11:7]));
    // R5
    word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_word_op |=> illegal_o || (result_o[63:32] == {32{result_o[31]}}));
    // R8
    cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> result_o[63:1] == 63'd0);
    // R9
    upper_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[6:0] == 7'b0110111) |=> result_o[11:0] == 12'd0);
endmodule

bind rv64_exec_unit exu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .result_o  (result_o),
    .rd_o      (rd_o),
    .wen_o     (wen_o),
    .illegal_o (illegal_o)
);

// File: tb/rv64_exec_unit_test.sv
`timescale 1ns/1ps
module rv64_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] a = '0, b = '0, pc = '0;
    logic [63:0] result;
    logic [4:0]  rd;
    logic        wen, illegal;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    rv64_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .src1_i(a), .src2_i(b),
        .pc_i(pc), .result_o(result), .rd_o(rd), .wen_o(wen), .illegal_o(illegal)
    );

    // expected {illegal, wen, rd, result}
    function automatic logic [70:0] model(input logic [31:0] w, input logic [63:0] x,
                                          input logic [63:0] y, input logic [63:0] p);
        logic [6:0]  o;
        logic [2:0]  f;
        logic [6:0]  g;
        logic [63:0] im, v, r;
        logic        bad, isw;
        int          sh;
        o = w[6:0]; f = w[14:12]; g = w[31:25];
        im = {{52{w[31]}}, w[31:20]};
        bad = 0; r = 0;
        isw = (o == 7'h3B) || (o == 7'h1B);
        if (o == 7'h37 || o == 7'h17) begin
            v = {{32{w[31]}}, w[31:12], 12'h0};
            r = (o == 7'h37) ? v : p + v;
        end else if (o == 7'h33 || o == 7'h13 || isw) begin
            v = (o == 7'h13 || o == 7'h1B) ? im : y;
            sh = isw ? int'(v[4:0]) : int'(v[5:0]);
            if (o == 7'h33 || o == 7'h3B)
                bad = !(g == 7'h00 || (g == 7'h20 && (f == 3'd0 || f == 3'd5)));
            else if (f == 3'd1)
                bad = (w[31:26] != 6'h00);
            else if (f == 3'd5)
                bad = !(w[31:26] == 6'h00 || w[31:26] == 6'h10);
            if (isw && !(f == 3'd0 || f == 3'd1 || f == 3'd5)) bad = 1;
            if (o == 7'h3B && f != 3'd0 && f != 3'd1 && f != 3'd5) bad = 1;
            if (o == 7'h1B && (f == 3'd1 || f == 3'd5) && w[25]) bad = 1;
            case (f)
                3'd0: r = (o[5] && g == 7'h20) ? x - v : x + v;
                3'd1: r = x << sh;
                3'd2: r = ($signed(x) < $signed(v)) ? 64'd1 : 64'd0;
                3'd3: r = (x < v) ? 64'd1 : 64'd0;
                3'd4: r = x ^ v;
                3'd5: begin
                    if (w[30]) begin
                        if (isw) r = {{32{x[31]}}, x[31:0]} >>> 0;
                        if (isw) for (int k = 0; k < sh; k++) r = {r[63], r[63:1]};
                        else begin
                            r = x;
                            for (int k = 0; k < sh; k++) r = {r[63], r[63:1]};
                        end
                    end else begin
                        r = isw ? {32'h0, x[31:0]} >> sh : x >> sh;
                    end
                end
                3'd6: r = x | v;
                default: r = x & v;
            endcase
            if (isw) r = {{32{r[31]}}, r[31:0]};
        end else begin
            bad = 1;
        end
        if (bad) r = 0;
        return {bad, !bad && (w[11:7] != 0), w[11:7], r};
    endfunction

    task automatic run(input logic [31:0] w, input logic [63:0] x, input logic [63:0] y,
                       input logic [63:0] p, input string req);
        logic [70:0] exp, got;
        @(negedge clk);
        instr = w; a = x; b = y; pc = p;
        exp = model(w, x, y, p);
        @(negedge clk);
        got = {illegal, wen, rd, result};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s instr=%h actual=%h expected=%h", req, w, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [31:0] w);
        case (w[6:0])
            7'h33: return "R2";
            7'h13: return "R3";
            7'h3B: return "R5";
            7'h1B: return "R6";
            7'h37, 7'h17: return "R9";
            default: return "R11";
        endcase
    endfunction

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        #1;
        checks++;   // R1: reset state
        if ({illegal, wen, rd, result} !== 71'd0) begin
            errors++;
            $display("FAIL R1 actual=%h expected=0", {illegal, wen, rd, result});
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;   // R1: first cycle after reset
        if ({illegal, wen, rd, result} !== 71'd0) begin
            errors++;
            $display("FAIL R1 actual=%h expected=0", {illegal, wen, rd, result});
        end
        // R2 add overflow wraps, sub
        run(32'h002080B3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, "R2");
        run(32'h402080B3, 64'd0, 64'd1, 0, "R2");
        // R3 negative immediate add (imm -1)
        run(32'hFFF08093, 64'd5, 0, 0, "R3");
        // R4 shift amount 65 masked to 1
        run(32'h002090B3, 64'h8000_0000_0000_0001, 64'd65, 0, "R4");
        run(32'h43F0D093, 64'h8000_0000_0000_0000, 0, 0, "R4");
        // R5 word add producing negative
        run(32'h002080BB, 64'h7FFF_FFFF, 64'd1, 0, "R5");
        // R6 word sra, amount 33 -> 1, sign from bit 31
        run(32'h4020D0BB, 64'h0000_0000_8000_0000, 64'd33, 0, "R6");
        run(32'h4010D09B, 64'hFFFF_FFFF_0000_0004, 0, 0, "R6");
        // R7 word immediate shift with bit 25 set
        run(32'h0200909B, 64'd1, 0, 0, "R7");
        // R8 sltiu with imm -1: rs1=5 < 0xFFFF..FF
        run(32'hFFF0B093, 64'd5, 0, 0, "R8");
        run(32'h0020A0B3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, "R8");
        // R9 load-upper negative, PC-relative
        run(32'h800000B7, 0, 0, 0, "R9");
        run(32'h00001097, 0, 0, 64'h1000, "R9");
        // R10 destination x0
        run(32'h00208033, 64'd1, 64'd1, 0, "R10");
        // R11 unknown opcode and bad funct7
        run(32'h0020807F, 64'd1, 64'd1, 0, "R11");
        run(32'h022080B3, 64'd1, 64'd1, 0, "R11");
        for (int i = 0; i < 600; i++) begin
            logic [6:0]  opcs [8] = '{7'h33, 7'h13, 7'h3B, 7'h1B, 7'h37, 7'h17, 7'h63, 7'h7F};
            logic [6:0]  f7s [4] = '{7'h00, 7'h20, 7'h01, 7'h00};
            logic [31:0] w;
            w = $urandom;
            w[6:0] = opcs[$urandom_range(0, 7)];
            if ($urandom_range(0, 3) != 0) w[31:25] = f7s[$urandom_range(0, 3)];
            run(w, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, tag_of(w));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule